// File: doc/BRIEF.md
# Accumulator Processor with Index Register

This block is a small multi-cycle processor with a single accumulator (AC), one index register (IX) and a program counter (PC). Program and data share one synchronous memory. Each instruction is fetched from that memory, decoded, and then executed. If the instruction needs an operand, the operand is read from the same memory first. Stores go back to the same memory, so a program can patch its own instruction words.

Memory operands use an absolute address. When the word's index flag is set, IX is added to that address. Two instructions act on the address field of a memory word alone: one loads that field into AC, and the other overwrites that field in memory. Dedicated index instructions load, store and bump IX. A test-and-increment branch on IX gives compact counted loops. A HALT instruction stops the machine until the next reset.

Top module: `acc_ix_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it, PC, AC and IX are zero, the memory address output is 0, write enable is low and `halted` is low. The first fetch is from address 0.
- R2: An instruction word carries the opcode in bits [15:12], the index flag in bit 11 and the address/immediate field in bits [10:0]. The opcodes are 0 HALT, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 SHL, 6 SHR, 7 JUMP, 8 JGE, 9 LDADR, A STADR, B JZI, C LDI, D STI, E INCI and F no-op.
- R3: LOAD sets AC to M[ea]. STORE writes AC to M[ea]. ADD and SUB set AC to AC plus or minus M[ea], wrapping modulo 2^16.
- R4: SHL shifts AC left by one and fills with zero. SHR shifts AC right by one arithmetically, keeping the sign. Both ignore the address field.
- R5: JUMP loads PC with ea. JGE loads PC with ea only when AC bit 15 is clear, so zero counts as taken. When JGE is not taken, execution falls through to PC+1.
- R6: LDADR sets AC to bits [10:0] of M[ea] with zeros above. STADR replaces bits [10:0] of M[ea] with AC[10:0] and leaves bits [15:11] unchanged.
- R7: With the index flag set, ea = field + IX modulo 2048. With the flag clear, ea = field. This applies to every opcode except JZI and INCI.
- R8: JZI branches to the field when IX is zero and leaves IX unchanged. Otherwise it adds one to IX and falls through.
- R9: LDI loads IX with bits [10:0] of M[ea], dropping the upper bits. STI writes IX to M[ea] sign-extended from bit 10.
- R10: INCI adds the 11-bit field to IX modulo 2048 and leaves AC unchanged.
- R11: Instructions and data share one memory. A store to an instruction word changes what a later fetch of that address returns.
- R12: HALT stops fetching. The memory address stays on the HALT word, `halted` goes high and stays high, and no write occurs until reset. Opcode F changes no register or memory word.
- R13: Memory reads return data one cycle after the address. Each store asserts write enable for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory word address, registered |
| mem_wdata | output | 16 | Memory write data, registered |
| mem_we | output | 1 | Memory write enable, registered |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once HALT has executed, until reset |

## Verification
The bench runs a counted vector-add loop driven by the test-and-increment branch. That loop exposes an off-by-one in the branch or in the indexed address: such a design writes the wrong C word or stomps on the guard word just past the array. Sign-sensitive cases are covered too. Signed overflow on ADD and SUB is included, and so is SHR of a negative value, which a logical shift would turn positive. JGE is tested with AC exactly zero, which a design using "greater than" would wrongly not take. The address-field store is checked for keeping the upper bits of the target, and a variant shows that patching a not-yet-fetched instruction changes what runs. IX truncation on load and sign extension on store are checked with values whose upper bits disagree. After HALT the bench checks that the address holds still and that no write slips out.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT  = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_SHL   = 4'h5,
    OP_SHR   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_JGE   = 4'h8,
    OP_LDADR = 4'h9,
    OP_STADR = 4'hA,
    OP_JZI   = 4'hB,
    OP_LDI   = 4'hC,
    OP_STI   = 4'hD,
    OP_INCI  = 4'hE,
    OP_NOP   = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_MEMRD,
    ST_EXEC,
    ST_WRITE,
    ST_HALT
  } state_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic [WORD_W-1:0] instr,
  output opcode_e           op,
  output logic              idx,
  output logic [ADDR_W-1:0] field,
  output logic              is_read,
  output logic              is_store,
  output logic              is_rmw
);
  always_comb begin
    op       = opcode_e'(instr[WORD_W-1 -: OPC_W]);
    idx      = instr[ADDR_W];
    field    = instr[ADDR_W-1:0];
    is_read  = 1'b0;
    is_store = 1'b0;
    is_rmw   = 1'b0;
    unique case (op)
      OP_LOAD, OP_ADD, OP_SUB, OP_LDADR, OP_LDI: is_read  = 1'b1;
      OP_STORE, OP_STI:                          is_store = 1'b1;
      OP_STADR:                                  is_rmw   = 1'b1;
      default: ;
    endcase
  end

  // R2
  always_comb begin
    onehot_class_chk: assert ($onehot0({is_read, is_store, is_rmw}));
  end
endmodule

// File: rtl/acc_agu.sv
module acc_agu #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] field,
  input  logic              idx,
  input  logic [ADDR_W-1:0] ix,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = idx ? ix : '0;
    ea     = field + offset;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11
) (
  input  opcode_e           op,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] operand,
  input  logic [ADDR_W-1:0] ix,
  output logic [WORD_W-1:0] ac_next,
  output logic [WORD_W-1:0] rmw_word,
  output logic [WORD_W-1:0] ix_word
);
  localparam int HI_W = WORD_W - ADDR_W;

  always_comb begin
    unique case (op)
      OP_LOAD:  ac_next = operand;
      OP_ADD:   ac_next = ac + operand;
      OP_SUB:   ac_next = ac - operand;
      OP_SHL:   ac_next = {ac[WORD_W-2:0], 1'b0};
      OP_SHR:   ac_next = {ac[WORD_W-1], ac[WORD_W-1:1]};
      OP_LDADR: ac_next = {{HI_W{1'b0}}, operand[ADDR_W-1:0]};
      default:  ac_next = ac;
    endcase
    rmw_word = {operand[WORD_W-1:ADDR_W], ac[ADDR_W-1:0]};
    ix_word  = {{HI_W{ix[ADDR_W-1]}}, ix};
  end
endmodule

// File: rtl/acc_ix_cpu.sv
module acc_ix_cpu
  import acc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);
  localparam logic [ADDR_W-1:0] IX_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  state_e            state;
  logic [ADDR_W-1:0] pc, ix, addr_q;
  logic [WORD_W-1:0] ac, ir, wdata_q;
  logic              we_q, halted_q;

  logic [WORD_W-1:0] dec_in;
  opcode_e           d_op;
  logic              d_idx, d_rd, d_st, d_rmw;
  logic [ADDR_W-1:0] d_field, ea, pc_inc;
  logic [WORD_W-1:0] alu_ac, alu_rmw, alu_ixw;

  assign dec_in = (state == ST_DECODE) ? mem_rdata : ir;
  assign pc_inc = pc + IX_ONE;

  acc_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
    .instr(dec_in), .op(d_op), .idx(d_idx), .field(d_field),
    .is_read(d_rd), .is_store(d_st), .is_rmw(d_rmw)
  );

  acc_agu #(.ADDR_W(ADDR_W)) u_agu (
    .field(d_field), .idx(d_idx), .ix(ix), .ea(ea)
  );

  acc_alu #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_alu (
    .op(d_op), .ac(ac), .operand(mem_rdata), .ix(ix),
    .ac_next(alu_ac), .rmw_word(alu_rmw), .ix_word(alu_ixw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      pc       <= '0;
      ac       <= '0;
      ix       <= '0;
      ir       <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir     <= mem_rdata;
          pc     <= pc_inc;
          addr_q <= pc_inc;
          if (d_rd || d_rmw) begin
            addr_q <= ea;
            state  <= ST_MEMRD;
          end else if (d_st) begin
            addr_q  <= ea;
            wdata_q <= (d_op == OP_STI) ? alu_ixw : ac;
            we_q    <= 1'b1;
            state   <= ST_WRITE;
          end else begin
            state <= ST_FETCH;
            unique case (d_op)
              OP_HALT: begin
                state    <= ST_HALT;
                halted_q <= 1'b1;
                pc       <= pc;
                addr_q   <= pc;
              end
              OP_SHL, OP_SHR: ac <= alu_ac;
              OP_JUMP: begin
                pc     <= ea;
                addr_q <= ea;
              end
              OP_JGE: begin
                if (!ac[WORD_W-1]) begin
                  pc     <= ea;
                  addr_q <= ea;
                end
              end
              OP_JZI: begin
                if (ix == '0) begin
                  pc     <= d_field;
                  addr_q <= d_field;
                end else begin
                  ix <= ix + IX_ONE;
                end
              end
              OP_INCI: ix <= ix + d_field;
              default: ;
            endcase
          end
        end
        ST_MEMRD: state <= ST_EXEC;
        ST_EXEC: begin
          if (d_op == OP_STADR) begin
            wdata_q <= alu_rmw;
            we_q    <= 1'b1;
            state   <= ST_WRITE;
          end else begin
            if (d_op == OP_LDI) ix <= mem_rdata[ADDR_W-1:0];
            else                ac <= alu_ac;
            addr_q <= pc;
            state  <= ST_FETCH;
          end
        end
        ST_WRITE: begin
          we_q   <= 1'b0;
          addr_q <= pc;
          state  <= ST_FETCH;
        end
        ST_HALT: ;
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
  assign halted    = halted_q;

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && !we_q));

  // R13
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q);

  // R10
  inci_ac_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && d_op == OP_INCI) |=> $stable(ac));

  // R8
  jzi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && d_op == OP_JZI && ix != '0) |=> (ix == $past(ix) + IX_ONE));

  // R11
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> (addr_q == pc));
endmodule

// File: tb/sim_acc_ix_cpu.sv
`timescale 1ns/1ps
module sim_acc_ix_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [15:0] mem [0:2047];
  int n_chk = 0;
  int n_err = 0;
  int wr_cnt = 0;

  always #2.5 clk = ~clk;

  acc_ix_cpu u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (!rst && mem_we) wr_cnt <= wr_cnt + 1;
  end

  // {instruction at word 1, M[0x100], M[0x101], expected M[0x102]}
  localparam logic [63:0] VEC [0:8] = '{
    64'h3101_1234_0F0F_2143,  // ADD
    64'h3101_7FFF_0001_8000,  // ADD overflow wrap
    64'h4101_0005_0007_FFFE,  // SUB negative
    64'h4101_8000_0001_7FFF,  // SUB wrap
    64'h5101_4321_0000_8642,  // SHL
    64'h6101_8642_0000_C321,  // SHR keeps sign
    64'h6101_0007_0000_0003,  // SHR positive
    64'h9101_1234_ABCD_03CD,  // LDADR
    64'hF101_0042_9999_0042   // opcode F no-op
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 2048; a++) mem[a] = 16'h0000;
  endtask

  task automatic run_prog(input string tag);
    int cyc;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    wr_cnt = 0;
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    n_chk++;
    if (!halted) begin
      n_err++;
      $display("FAIL %s: actual running expected halted", tag);
    end
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1 addr in reset", {5'd0, mem_addr}, 16'h0000);
    chk("R1 we in reset", {15'd0, mem_we}, 16'h0000);
    chk("R1 halted in reset", {15'd0, halted}, 16'h0000);

    // Table of R3 / R4 / R6 / R12 cases, each a LOAD, OP, STORE, HALT program
    for (int i = 0; i < 9; i++) begin
      clear_mem();
      mem[0] = 16'h1100;
      mem[1] = VEC[i][63:48];
      mem[2] = 16'h2102;
      mem[3] = 16'h0000;
      mem[11'h100] = VEC[i][47:32];
      mem[11'h101] = VEC[i][31:16];
      run_prog("R3 table run");
      chk($sformatf("R3/R4/R6/R12 vector %0d", i), mem[11'h102], VEC[i][15:0]);
    end
    // R12: after HALT the address holds and nothing is written
    repeat (10) @(negedge clk);
    chk("R12 halted stays", {15'd0, halted}, 16'h0001);
    chk("R12 address holds on HALT word", {5'd0, mem_addr}, 16'h0003);
    chk("R13 one write per store", wr_cnt[15:0], 16'h0001);

    // R1: reset clears halted again
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears halted", {15'd0, halted}, 16'h0000);

    // R5: JGE with AC = 0 is taken, with AC negative falls through; JUMP
    for (int k = 0; k < 2; k++) begin
      clear_mem();
      mem[0] = 16'h1100; mem[1] = 16'h8004; mem[2] = 16'h1101; mem[3] = 16'h7005;
      mem[4] = 16'h1102; mem[5] = 16'h2103; mem[6] = 16'h0000;
      mem[11'h100] = (k == 0) ? 16'h0000 : 16'h8000;
      mem[11'h101] = 16'h1111;
      mem[11'h102] = 16'h2222;
      run_prog("R5 run");
      chk("R5 JGE/JUMP path", mem[11'h103], (k == 0) ? 16'h2222 : 16'h1111);
    end

    // R7 / R8 / R2: vector add C[i] = A[i] + B[i], IX counts up from -4
    clear_mem();
    mem[0] = 16'hC300;  // LDI 0x300
    mem[1] = 16'hB007;  // JZI 7
    mem[2] = 16'h1A03;  // LOAD 0x203,IX
    mem[3] = 16'h3A13;  // ADD  0x213,IX
    mem[4] = 16'h2A23;  // STORE 0x223,IX
    mem[5] = 16'h7001;  // JUMP 1
    mem[7] = 16'hD301;  // STI 0x301
    mem[8] = 16'h0000;  // HALT
    mem[11'h300] = 16'hFFFC;
    mem[11'h301] = 16'h1234;
    mem[11'h200] = 16'd1;  mem[11'h201] = 16'd2;  mem[11'h202] = 16'd3;  mem[11'h203] = 16'h7FFF;
    mem[11'h210] = 16'd10; mem[11'h211] = 16'd20; mem[11'h212] = 16'd30; mem[11'h213] = 16'h0001;
    mem[11'h224] = 16'hDEAD;
    mem[11'h21F] = 16'hBEEF;
    run_prog("R8 loop run");
    chk("R7 C[0]", mem[11'h220], 16'd11);
    chk("R7 C[1]", mem[11'h221], 16'd22);
    chk("R7 C[2]", mem[11'h222], 16'd33);
    chk("R7 C[3]", mem[11'h223], 16'h8000);
    chk("R8 guard after C untouched", mem[11'h224], 16'hDEAD);
    chk("R8 guard before C untouched", mem[11'h21F], 16'hBEEF);
    chk("R8 IX zero at loop exit", mem[11'h301], 16'h0000);
    chk("R13 write count in loop", wr_cnt[15:0], 16'd5);

    // R9 / R10: LDI truncation, INCI, STI sign extension, AC untouched
    clear_mem();
    mem[0] = 16'h1303; mem[1] = 16'hC300; mem[2] = 16'hD302; mem[3] = 16'hE7FA;
    mem[4] = 16'hD305; mem[5] = 16'h2304; mem[6] = 16'h0000;
    mem[11'h300] = 16'hF805;
    mem[11'h303] = 16'h5A5A;
    run_prog("R9 run");
    chk("R9 LDI drops upper bits", mem[11'h302], 16'h0005);
    chk("R9 STI sign extends", mem[11'h305], 16'hFFFF);
    chk("R10 INCI leaves AC", mem[11'h304], 16'h5A5A);

    // R6: STADR keeps bits [15:11] of target
    clear_mem();
    mem[0] = 16'h1100; mem[1] = 16'hA101; mem[2] = 16'h0000;
    mem[11'h100] = 16'hF9AB;
    mem[11'h101] = 16'h5800;
    run_prog("R6 run");
    chk("R6 STADR merge", mem[11'h101], 16'h59AB);

    // R11: patch the address field of a later instruction
    clear_mem();
    mem[0] = 16'h1100; mem[1] = 16'hA003; mem[2] = 16'h7003; mem[3] = 16'h1104;
    mem[4] = 16'h2106; mem[5] = 16'h0000;
    mem[11'h100] = 16'h0105;
    mem[11'h104] = 16'h1111;
    mem[11'h105] = 16'h2222;
    run_prog("R11 run");
    chk("R11 patched instruction word", mem[11'h003], 16'h1105);
    chk("R11 patched load executed", mem[11'h106], 16'h2222);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule